// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Grouped Secondary Sources

This block combines 32 primary interrupt request lines and 11 secondary request lines into a single processor interrupt output. The secondary lines are arranged in clusters of three, and the last cluster has two lines. Each cluster drives one primary line once any of its latched, unmasked secondary requests is present. A fixed-priority arbiter selects one unmasked primary request. It records that request in a one-hot service register and records its bit number in an index register. Software uses the index register directly as the source number.

Software reaches every register through a small word-addressed bus. The address is 3 bits, writes are qualified by a write enable, and reads are combinational.

| Address | Register | Access |
|---|---|---|
| 0 | primary pending | write 1 to clear |
| 1 | primary mask | read/write, 1 masks |
| 2 | service | write 1 to clear |
| 3 | service index | read only |
| 4 | secondary pending | write 1 to clear |
| 5 | secondary mask | read/write, 1 masks |

The arbiter is a two-state machine.
- `ST_IDLE`: the service register is empty. Transition IDLE→SERVE happens on the first edge at which an unmasked primary request is pending, and loads the winner.
- `ST_SERVE`: the service register holds one bit. Transition SERVE→IDLE happens on the edge at which a software write clears that bit.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset the registers hold these values: primary pending 0, primary mask 0xFFFFFFFF, service 0, service index 0, secondary pending 0, secondary mask 0x7FF. `irq_out` is 0.
- R2: A high `main_req[i]` at a clock edge sets bit i of primary pending whatever the mask. A masked primary request never reaches the service register or `irq_out`.
- R3: The edge after a request is latched into primary pending, the lowest-numbered unmasked pending request is loaded into the service register. Only that one bit is set. The service index shows its bit number and `irq_out` is 1. So `irq_out` rises at the second edge after a `main_req` pulse is sampled.
- R4: While the service register is non-zero, the service register and the service index keep their values, even if new unmasked requests of higher priority arrive.
- R5: Writing 1 to a bit of primary pending or of the service register clears that bit. Writing 0 leaves it unchanged. Writing 0xFFFFFFFF clears every bit.
- R6: On the edge that clears the service bit, the service index becomes 0 and `irq_out` becomes 0. At the next edge the next candidate, if any, is loaded.
- R7: A high `sub_req[j]` at an edge sets bit j of secondary pending whatever the secondary mask. The clusters map as follows: secondary 0–2 drive primary 28, 3–5 drive primary 29, 6–8 drive primary 30, and 9–10 drive primary 31. A cluster line is high while one of its secondary pending bits is unmasked, and it sets its primary pending bit at the following edge.
- R8: Writing 1 to a bit of secondary pending clears that bit.
- R9: A masked secondary pending bit does not drive its cluster line. Clearing its mask bit later makes the line drive the request.
- R10: Writes to the service index address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_req | input | 32 | Primary request lines, sampled each edge |
| sub_req | input | 11 | Secondary request lines, sampled each edge |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Processor interrupt, high while the service register is non-zero |

## Verification
Each result is due a fixed number of edges after its cause:
- A `main_req` pulse shows in primary pending one edge after it is sampled, and in the service register and `irq_out` one edge later.
- A secondary request adds one more edge, because it passes through the cluster line into primary pending.
- Register writes take effect at their own edge. Clearing the service bit drops `irq_out` at that edge and loads the next winner at the following edge.

The bench drives stimulus and checks results at falling edges. Before each check it waits the exact number of edges listed above. It also checks at the intermediate edges that a result has not appeared early.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
    typedef enum logic [2:0] {
        RA_SRC_PEND  = 3'd0,
        RA_MAIN_MASK = 3'd1,
        RA_SVC_PEND  = 3'd2,
        RA_SVC_INDEX = 3'd3,
        RA_SUB_PEND  = 3'd4,
        RA_SUB_MASK  = 3'd5
    } reg_addr_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } arb_state_e;
endpackage

// File: rtl/irq_sub_cascade.sv
module irq_sub_cascade #(
    parameter int NUM_SUB  = 11,
    parameter int GRP_SIZE = 3,
    localparam int NUM_GRP = (NUM_SUB + GRP_SIZE - 1) / GRP_SIZE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SUB-1:0] sub_req,
    input  logic               pend_clr_wr,
    input  logic               mask_wr,
    input  logic [NUM_SUB-1:0] wdata,
    output logic [NUM_SUB-1:0] sub_pend,
    output logic [NUM_SUB-1:0] sub_mask,
    output logic [NUM_GRP-1:0] grp_line
);
    logic [NUM_SUB-1:0] live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_pend <= '0;
            sub_mask <= '1;
        end else begin
            sub_pend <= (sub_pend & ~(pend_clr_wr ? wdata : '0)) | sub_req;
            if (mask_wr)
                sub_mask <= wdata;
        end
    end

    assign live = sub_pend & ~sub_mask;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int LO = g * GRP_SIZE;
        localparam int HI = ((g + 1) * GRP_SIZE > NUM_SUB) ? NUM_SUB - 1 : (g + 1) * GRP_SIZE - 1;
        assign grp_line[g] = |live[HI:LO];
    end

    // R8: a write of 1 clears the bit unless a new request arrives with it
    a_r8_sub_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr_wr && wdata[0] && !sub_req[0]) |=> !sub_pend[0]);
    // R9: a fully masked cluster never drives its line
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_mask == '1) |-> (grp_line == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    always_comb begin
        found  = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found  = 1'b1;
                idx    = IW'(i);
                onehot = '0;
                onehot[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl #(
    parameter int NUM_MAIN  = 32,
    parameter int NUM_SUB   = 11,
    parameter int GRP_SIZE  = 3,
    parameter int CASC_BASE = 28,
    localparam int IW       = $clog2(NUM_MAIN),
    localparam int NUM_GRP  = (NUM_SUB + GRP_SIZE - 1) / GRP_SIZE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_MAIN-1:0] main_req,
    input  logic [NUM_SUB-1:0]  sub_req,
    input  logic [2:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [NUM_MAIN-1:0] bus_wdata,
    output logic [NUM_MAIN-1:0] bus_rdata,
    output logic                irq_out
);
    import irq_cascade_pkg::*;

    reg_addr_e          addr_e;
    arb_state_e         state, state_nxt;
    logic [NUM_MAIN-1:0] src_pend, main_mask, svc_pend, svc_left, casc_vec;
    logic [NUM_MAIN-1:0] pick_hot;
    logic [IW-1:0]       svc_idx, pick_idx;
    logic                pick_found;
    logic [NUM_SUB-1:0]  sub_pend, sub_mask;
    logic [NUM_GRP-1:0]  grp_line;
    logic                wr_src, wr_mask, wr_svc, wr_sub_pend, wr_sub_mask;

    assign addr_e      = reg_addr_e'(bus_addr);
    assign wr_src      = bus_wr && (addr_e == RA_SRC_PEND);
    assign wr_mask     = bus_wr && (addr_e == RA_MAIN_MASK);
    assign wr_svc      = bus_wr && (addr_e == RA_SVC_PEND);
    assign wr_sub_pend = bus_wr && (addr_e == RA_SUB_PEND);
    assign wr_sub_mask = bus_wr && (addr_e == RA_SUB_MASK);

    irq_sub_cascade #(.NUM_SUB(NUM_SUB), .GRP_SIZE(GRP_SIZE)) u_sub (
        .clk(clk), .rst_n(rst_n), .sub_req(sub_req),
        .pend_clr_wr(wr_sub_pend), .mask_wr(wr_sub_mask),
        .wdata(bus_wdata[NUM_SUB-1:0]),
        .sub_pend(sub_pend), .sub_mask(sub_mask), .grp_line(grp_line)
    );

    always_comb begin
        casc_vec = '0;
        for (int g = 0; g < NUM_GRP; g++)
            casc_vec[CASC_BASE + g] = grp_line[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_pend  <= '0;
            main_mask <= '1;
        end else begin
            src_pend <= (src_pend & ~(wr_src ? bus_wdata : '0)) | main_req | casc_vec;
            if (wr_mask)
                main_mask <= bus_wdata;
        end
    end

    irq_prio_pick #(.N(NUM_MAIN)) u_pick (
        .cand(src_pend & ~main_mask), .found(pick_found),
        .idx(pick_idx), .onehot(pick_hot)
    );

    assign svc_left = svc_pend & ~(wr_svc ? bus_wdata : '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (pick_found)       state_nxt = ST_SERVE;
            ST_SERVE: if (svc_left == '0)   state_nxt = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_pend <= '0;
            svc_idx  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (pick_found) begin
                    svc_pend <= pick_hot;
                    svc_idx  <= pick_idx;
                end
                ST_SERVE: begin
                    svc_pend <= svc_left;
                    if (svc_left == '0) svc_idx <= '0;
                end
            endcase
        end
    end

    assign irq_out = (state == ST_SERVE);

    always_comb begin
        case (addr_e)
            RA_SRC_PEND:  bus_rdata = src_pend;
            RA_MAIN_MASK: bus_rdata = main_mask;
            RA_SVC_PEND:  bus_rdata = svc_pend;
            RA_SVC_INDEX: bus_rdata = NUM_MAIN'(svc_idx);
            RA_SUB_PEND:  bus_rdata = NUM_MAIN'(sub_pend);
            RA_SUB_MASK:  bus_rdata = NUM_MAIN'(sub_mask);
            default:      bus_rdata = '0;
        endcase
    end

    // R3: at most one service bit
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc_pend));
    // R3: index names the set service bit
    a_r3_index_match: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_pend != '0) |-> svc_pend[svc_idx]);
    // R3: irq follows the service register
    a_r3_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (svc_pend != '0));
    // R2: a newly loaded winner was unmasked and pending
    a_r2_unmasked_win: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_pend != '0 && $past(svc_pend) == '0) |->
        (($past(src_pend & ~main_mask) & svc_pend) != '0));
    // R4: the service register holds without a clearing write
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_pend != '0 && !wr_svc) |=> $stable(svc_pend) && $stable(svc_idx));
    // R6: the index is 0 whenever nothing is in service
    a_r6_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_pend == '0) |-> (svc_idx == '0));
endmodule

// File: tb/irq_cascade_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] main_req = '0;
    logic [10:0] sub_req = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    int          n_chk = 0, n_err = 0, cyc = 0;
    logic        done = 1'b0;

    localparam logic [2:0] A_SRC = 3'd0, A_MSK = 3'd1, A_SVC = 3'd2,
                           A_IDX = 3'd3, A_SPD = 3'd4, A_SMK = 3'd5;

    irq_cascade_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .main_req(main_req), .sub_req(sub_req),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run hung, act=%0d exp<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        chk(req, bus_rdata, exp);
    endtask

    task automatic pulse_main(input logic [31:0] bits);
        @(negedge clk); main_req = bits;
        @(negedge clk); main_req = '0;
    endtask

    task automatic pulse_sub(input logic [10:0] bits);
        @(negedge clk); sub_req = bits;
        @(negedge clk); sub_req = '0;
    endtask

    task automatic t_reset();
        rd_chk("R1 src", A_SRC, 32'h0);
        rd_chk("R1 mask", A_MSK, 32'hFFFF_FFFF);
        rd_chk("R1 svc", A_SVC, 32'h0);
        rd_chk("R1 idx", A_IDX, 32'h0);
        rd_chk("R1 subpend", A_SPD, 32'h0);
        rd_chk("R1 submask", A_SMK, 32'h7FF);
        chk("R1 irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_masked();
        pulse_main(32'h20);
        wait_cyc(3);
        rd_chk("R2 src set while masked", A_SRC, 32'h20);
        rd_chk("R2 svc empty", A_SVC, 32'h0);
        chk("R2 irq low", {31'b0, irq_out}, 32'h0);
        reg_wr(A_SRC, 32'h20);
        rd_chk("R5 clear one", A_SRC, 32'h0);
    endtask

    task automatic t_priority();
        reg_wr(A_MSK, ~32'h88);
        pulse_main(32'h88);
        rd_chk("R3 not yet", A_SVC, 32'h0);
        chk("R3 irq not yet", {31'b0, irq_out}, 32'h0);
        wait_cyc(1);
        rd_chk("R3 lowest wins", A_SVC, 32'h8);
        rd_chk("R3 index", A_IDX, 32'd3);
        chk("R3 irq", {31'b0, irq_out}, 32'h1);
        reg_wr(A_MSK, ~32'h8A);
        pulse_main(32'h2);
        wait_cyc(1);
        rd_chk("R4 svc held", A_SVC, 32'h8);
        rd_chk("R4 idx held", A_IDX, 32'd3);
        reg_wr(A_SVC, 32'h0);
        rd_chk("R5 zero write", A_SVC, 32'h8);
        reg_wr(A_SRC, 32'h8);
        rd_chk("R5 src clear", A_SRC, 32'h82);
        reg_wr(A_SVC, 32'h8);
        rd_chk("R6 svc cleared", A_SVC, 32'h0);
        rd_chk("R6 idx zero", A_IDX, 32'h0);
        chk("R6 irq low", {31'b0, irq_out}, 32'h0);
        wait_cyc(1);
        rd_chk("R6 next winner", A_SVC, 32'h2);
        rd_chk("R6 next idx", A_IDX, 32'd1);
        reg_wr(A_IDX, 32'd5);
        rd_chk("R10 idx read only", A_IDX, 32'd1);
        reg_wr(A_SRC, 32'hFFFF_FFFF);
        rd_chk("R5 all ones src", A_SRC, 32'h0);
        reg_wr(A_SVC, 32'hFFFF_FFFF);
        wait_cyc(2);
        rd_chk("R5 all ones svc", A_SVC, 32'h0);
        chk("R5 irq idle", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_sub();
        reg_wr(A_MSK, 32'h0FFF_FFFF);
        pulse_sub(11'h010);
        wait_cyc(2);
        rd_chk("R7 subpend while masked", A_SPD, 32'h10);
        rd_chk("R9 masked no cascade", A_SRC, 32'h0);
        chk("R9 irq low", {31'b0, irq_out}, 32'h0);
        reg_wr(A_SMK, 32'h7EF);
        wait_cyc(1);
        rd_chk("R9 cascade src", A_SRC, 32'h2000_0000);
        rd_chk("R7 svc not yet", A_SVC, 32'h0);
        wait_cyc(1);
        rd_chk("R7 group1 -> 29", A_SVC, 32'h2000_0000);
        rd_chk("R7 idx 29", A_IDX, 32'd29);
        reg_wr(A_SPD, 32'h10);
        rd_chk("R8 sub clear", A_SPD, 32'h0);
        reg_wr(A_SRC, 32'h2000_0000);
        reg_wr(A_SVC, 32'h2000_0000);
        wait_cyc(2);
        rd_chk("R8 no re-raise", A_SRC, 32'h0);
        chk("R8 irq low", {31'b0, irq_out}, 32'h0);
        reg_wr(A_SMK, 32'h3FE);
        pulse_sub(11'h401);
        wait_cyc(2);
        rd_chk("R7 group0 -> 28 wins", A_SVC, 32'h1000_0000);
        rd_chk("R7 idx 28", A_IDX, 32'd28);
        rd_chk("R7 both lines", A_SRC, 32'h9000_0000);
        reg_wr(A_SPD, 32'h001);
        reg_wr(A_SRC, 32'h1000_0000);
        reg_wr(A_SVC, 32'h1000_0000);
        wait_cyc(1);
        rd_chk("R7 group3 -> 31", A_SVC, 32'h8000_0000);
        rd_chk("R7 idx 31", A_IDX, 32'd31);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_masked();
        t_priority();
        t_sub();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule